// File: doc/BRIEF.md
# Dual-Mode Voted ALU Cell Cluster

This block groups four small ALU cells. Each cell holds its own configuration word and accumulator. A stored mode bit decides how the cluster runs. In independent mode every cell runs its own operation on its own operands, so the cluster offers four units of compute. In redundant mode cells 0, 1 and 2 become replicas of one logical cell. All three take cell 0's operands and configuration, and a hard-wired bitwise majority voter merges their results into one output. Cell 3 keeps running on its own in both modes.

The mode bit is kept in three copies and read through a voter. Each copy is rewritten from the voted value on every clock, so a flipped copy is repaired on the next edge. The voter adds no configuration bits.

Upset-injection masks let a verification environment flip single bits. A mask can hit any cell's configuration or accumulator, or any copy of the mode bit. With a parameter, a cell's own storage can also be built as three voted copies.

Top module: `tmr_cell_cluster`

## Requirements
- R1: After reset all cell outputs and the voted output are zero, the cluster is in independent mode, and every configuration word is zero (operation ZERO).
- R2: Each cell's result appears on its output one clock after its operands and configuration are sampled. The operation codes are 0 ZERO (result 0), 1 ADD, 2 SUB (a-b), 3 AND, 4 OR, 5 XOR, 6 MAC and 7 LDACC, with all arithmetic taken modulo 2^W.
- R3: A configuration word holds the operation in bits [W+3:W+1], an immediate-select flag in bit W and an immediate value in bits [W-1:0]. When the flag is set, the immediate value replaces operand b. A word is written at the clock edge where its write strobe is high and takes effect from the next cycle.
- R4: MAC adds a*b (truncated to W bits) to the cell's accumulator and outputs the new accumulator value. LDACC loads operand a into the accumulator and outputs a. No other operation changes the accumulator.
- R5: In independent mode (stored mode 0), every cell uses its own operand slot and configuration strobe, and the voted output equals cell 0's result.
- R6: In redundant mode (stored mode 1), cells 1 and 2 take operands and configuration from slot 0 and load it when strobe 0 is high. Their own operand slots and strobes are ignored.
- R7: In redundant mode the voted output is the bitwise majority of the results of cells 0, 1 and 2.
- R8: Cell 3 uses its own operands and configuration in both modes.
- R9: In redundant mode, a bit flip in the configuration or accumulator of any one replica leaves the voted output equal to the result of a clean replica.
- R10: The mode bit is written into all three copies when the mode strobe is high. A flip of any one copy in a cycle does not change the mode.
- R11: An upset mask is XORed into the stored value at the clock edge. It acts on top of a write or accumulator update made at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_in | input | 1 | New mode: 1 redundant, 0 independent |
| upset_mode | input | 3 | Per-copy flip of the stored mode bit |
| cfg_we | input | 4 | Per-slot configuration write strobe |
| cfg_in | input | 4*(W+4) | Per-slot configuration words, slot i at [i*(W+4) +: W+4] |
| opa | input | 4*W | Per-slot operand a |
| opb | input | 4*W | Per-slot operand b |
| upset_cfg | input | 4*(W+4) | Per-cell flip mask for the configuration word |
| upset_acc | input | 4*W | Per-cell flip mask for the accumulator |
| cell_out | output | 4*W | Per-cell registered results |
| voted_out | output | W | Majority of cells 0..2 in redundant mode, cell 0 otherwise |

## Verification
In independent mode the cluster is driven with distinct configurations and operands in every slot. This shows whether each cell keeps its own path and whether the immediate replaces operand b. In redundant mode the slots 1 and 2 carry deliberately different operands and configuration writes, so any leak of those slots shows up on the replica outputs. Single-bit flips into one replica's configuration opcode or accumulator, and into one mode copy at a time, separate a true majority vote from a design that just forwards one replica. Flips made at the same edge as a write check that the mask is applied after the write.

// File: rtl/clus_pkg.sv
package clus_pkg;
    localparam int CELLS    = 4;
    localparam int OP_W     = 3;
    localparam int REPLICAS = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ZERO  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_MAC   = 3'd6,
        OP_LDACC = 3'd7
    } alu_op_e;
endpackage

// File: rtl/tri_store.sv
module tri_store #(
    parameter int W      = 8,
    parameter bit TRIPLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    input  logic [W-1:0] flip,
    input  logic [2:0]   flip_copy,
    output logic [W-1:0] q
);
    if (TRIPLE) begin : g_tri
        logic [W-1:0] copy_q [3];
        logic [W-1:0] copy_d [3];
        logic [W-1:0] voted;
        logic [W-1:0] base;

        always_comb begin
            voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);
            base  = we ? din : voted;
            for (int k = 0; k < 3; k++) begin
                copy_d[k] = base ^ (flip & {W{flip_copy[k]}});
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int k = 0; k < 3; k++) copy_q[k] <= '0;
            end else begin
                for (int k = 0; k < 3; k++) copy_q[k] <= copy_d[k];
            end
        end

        assign q = voted;

        // R10
        single_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!we && $countones(flip_copy) <= 1) |=> $stable(q));
    end else begin : g_one
        logic [W-1:0] one_q;
        logic [W-1:0] one_d;

        always_comb begin
            one_d = (we ? din : one_q) ^ (flip & {W{|flip_copy}});
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) one_q <= '0;
            else        one_q <= one_d;
        end

        assign q = one_q;
    end

    // R11
    clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ((flip & {W{|flip_copy}}) == '0)) |=> (q == $past(din)));
endmodule

// File: rtl/cell_unit.sv
module cell_unit
    import clus_pkg::*;
#(
    parameter int W      = 16,
    parameter bit TRIPLE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ld,
    input  logic [W+OP_W:0]     cfg_din,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  logic [W+OP_W:0]     cfg_flip,
    input  logic [W-1:0]        acc_flip,
    output logic [W-1:0]        res,
    output logic [W+OP_W:0]     cfg_q
);
    localparam int CFG_W = W + OP_W + 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] acc;
        logic         acc_we;
    } cell_nxt_t;

    cell_nxt_t    nxt_d;
    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic [W-1:0] prod;
    logic [W-1:0] acc_q;
    logic [W-1:0] res_q;

    tri_store #(.W(CFG_W), .TRIPLE(TRIPLE)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_ld), .din(cfg_din),
        .flip(cfg_flip), .flip_copy(3'b001), .q(cfg_q)
    );

    tri_store #(.W(W), .TRIPLE(TRIPLE)) u_acc (
        .clk(clk), .rst_n(rst_n), .we(nxt_d.acc_we), .din(nxt_d.acc),
        .flip(acc_flip), .flip_copy(3'b001), .q(acc_q)
    );

    tri_store #(.W(W), .TRIPLE(TRIPLE)) u_res (
        .clk(clk), .rst_n(rst_n), .we(1'b1), .din(nxt_d.res),
        .flip('0), .flip_copy(3'b000), .q(res_q)
    );

    always_comb begin
        op     = alu_op_e'(cfg_q[CFG_W-1 -: OP_W]);
        b_eff  = cfg_q[W] ? cfg_q[W-1:0] : b;
        prod   = a * b_eff;
        nxt_d  = '{res: '0, acc: acc_q, acc_we: 1'b0};
        unique case (op)
            OP_ZERO:  nxt_d.res = '0;
            OP_ADD:   nxt_d.res = a + b_eff;
            OP_SUB:   nxt_d.res = a - b_eff;
            OP_AND:   nxt_d.res = a & b_eff;
            OP_OR:    nxt_d.res = a | b_eff;
            OP_XOR:   nxt_d.res = a ^ b_eff;
            OP_MAC: begin
                nxt_d.acc    = acc_q + prod;
                nxt_d.acc_we = 1'b1;
                nxt_d.res    = acc_q + prod;
            end
            OP_LDACC: begin
                nxt_d.acc    = a;
                nxt_d.acc_we = 1'b1;
                nxt_d.res    = a;
            end
            default:  nxt_d.res = '0;
        endcase
    end

    assign res = res_q;

    // R2
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> (res_q == $past(a + b_eff)));

    // R4
    ldacc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDACC && acc_flip == '0) |=> (acc_q == $past(a)));
endmodule

// File: rtl/tmr_cell_cluster.sv
module tmr_cell_cluster
    import clus_pkg::*;
#(
    parameter int W           = 16,
    parameter bit CELL_TRIPLE = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_we,
    input  logic                          mode_in,
    input  logic [2:0]                    upset_mode,
    input  logic [CELLS-1:0]              cfg_we,
    input  logic [CELLS*(W+OP_W+1)-1:0]   cfg_in,
    input  logic [CELLS*W-1:0]            opa,
    input  logic [CELLS*W-1:0]            opb,
    input  logic [CELLS*(W+OP_W+1)-1:0]   upset_cfg,
    input  logic [CELLS*W-1:0]            upset_acc,
    output logic [CELLS*W-1:0]            cell_out,
    output logic [W-1:0]                  voted_out
);
    localparam int CFG_W = W + OP_W + 1;

    logic         red_mode;
    logic [W-1:0] res_w  [CELLS];
    logic [CFG_W-1:0] cfgq_w [CELLS];

    tri_store #(.W(1), .TRIPLE(1'b1)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(mode_we), .din(mode_in),
        .flip(1'b1), .flip_copy(upset_mode), .q(red_mode)
    );

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        localparam int SRC_RED = (i >= 1 && i < REPLICAS) ? 0 : i;

        logic             ld_w;
        logic [CFG_W-1:0] din_w;
        logic [W-1:0]     a_w;
        logic [W-1:0]     b_w;

        always_comb begin
            if (red_mode) begin
                ld_w  = cfg_we[SRC_RED];
                din_w = cfg_in[SRC_RED*CFG_W +: CFG_W];
                a_w   = opa[SRC_RED*W +: W];
                b_w   = opb[SRC_RED*W +: W];
            end else begin
                ld_w  = cfg_we[i];
                din_w = cfg_in[i*CFG_W +: CFG_W];
                a_w   = opa[i*W +: W];
                b_w   = opb[i*W +: W];
            end
        end

        cell_unit #(.W(W), .TRIPLE(CELL_TRIPLE)) u_cell (
            .clk(clk), .rst_n(rst_n), .cfg_ld(ld_w), .cfg_din(din_w),
            .a(a_w), .b(b_w),
            .cfg_flip(upset_cfg[i*CFG_W +: CFG_W]),
            .acc_flip(upset_acc[i*W +: W]),
            .res(res_w[i]), .cfg_q(cfgq_w[i])
        );

        assign cell_out[i*W +: W] = res_w[i];
    end

    always_comb begin
        if (red_mode) begin
            voted_out = (res_w[0] & res_w[1]) | (res_w[0] & res_w[2]) | (res_w[1] & res_w[2]);
        end else begin
            voted_out = res_w[0];
        end
    end

    // R7
    pair_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_mode && res_w[1] == res_w[2]) |-> (voted_out == res_w[1]));

    // R6
    replica_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_mode && cfg_we[0] && upset_cfg[REPLICAS*CFG_W-1:0] == '0)
        |=> (cfgq_w[0] == cfgq_w[1] && cfgq_w[1] == cfgq_w[2]));
endmodule

// File: tb/tmr_cell_cluster_tb_top.sv
`timescale 1ns/1ps
module tmr_cell_cluster_tb_top;
    localparam int W  = 16;
    localparam int CW = W + 4;
    localparam int N  = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic            mode_we, mode_in;
    logic [2:0]      upset_mode;
    logic [N-1:0]    cfg_we;
    logic [N*CW-1:0] cfg_in, upset_cfg;
    logic [N*W-1:0]  opa, opb, upset_acc, cell_out;
    logic [W-1:0]    voted_out;

    tmr_cell_cluster #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .upset_mode(upset_mode), .cfg_we(cfg_we), .cfg_in(cfg_in),
        .opa(opa), .opb(opb), .upset_cfg(upset_cfg), .upset_acc(upset_acc),
        .cell_out(cell_out), .voted_out(voted_out)
    );

    logic [CW-1:0] m_cfg [N];
    logic [W-1:0]  m_acc [N];
    logic [W-1:0]  m_res [N];
    logic          m_mode [3];
    int            checks = 0;
    int            failures = 0;
    string         cur_req = "R1";
    bit            done = 1'b0;

    function automatic logic [W-1:0] maj(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic logic mode_now();
        return (m_mode[0] & m_mode[1]) | (m_mode[0] & m_mode[2]) | (m_mode[1] & m_mode[2]);
    endfunction

    function automatic logic [CW-1:0] mkcfg(int op, bit ui, logic [W-1:0] imm);
        logic [2:0] o = 3'(op);
        return {o, ui, imm};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic red = mode_now();
        for (int i = 0; i < N; i++) check(cur_req, cell_out[i*W +: W], m_res[i]);
        check(cur_req, voted_out, red ? maj(m_res[0], m_res[1], m_res[2]) : m_res[0]);
    endtask

    task automatic model_edge();
        logic red = mode_now();
        logic mv  = red;
        for (int i = 0; i < N; i++) begin
            int s = (red && (i == 1 || i == 2)) ? 0 : i;
            logic [CW-1:0] c = m_cfg[i];
            logic [W-1:0] a = opa[s*W +: W];
            logic [W-1:0] b = c[W] ? c[W-1:0] : opb[s*W +: W];
            logic [W-1:0] r = '0;
            logic [W-1:0] acc = m_acc[i];
            case (int'(c[CW-1 -: 3]))
                1: r = a + b;
                2: r = a - b;
                3: r = a & b;
                4: r = a | b;
                5: r = a ^ b;
                6: begin acc = m_acc[i] + W'(a * b); r = acc; end
                7: begin acc = a; r = a; end
                default: r = '0;
            endcase
            m_res[i] = r;
            m_acc[i] = acc ^ upset_acc[i*W +: W];
            m_cfg[i] = (cfg_we[s] ? cfg_in[s*CW +: CW] : c) ^ upset_cfg[i*CW +: CW];
        end
        for (int k = 0; k < 3; k++) m_mode[k] = (mode_we ? mode_in : mv) ^ upset_mode[k];
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        cfg_we = '0; mode_we = 1'b0; upset_mode = '0; upset_cfg = '0; upset_acc = '0;
    endtask

    task automatic set_cfg(int i, int op, bit ui, logic [W-1:0] imm);
        cfg_in[i*CW +: CW] = mkcfg(op, ui, imm);
        cfg_we[i] = 1'b1;
    endtask

    task automatic set_ops(int i, logic [W-1:0] a, logic [W-1:0] b);
        opa[i*W +: W] = a;
        opb[i*W +: W] = b;
    endtask

    task automatic random_run(int n, bit slot0_only);
        for (int t = 0; t < n; t++) begin
            for (int i = 0; i < N; i++) begin
                set_ops(i, W'($urandom), W'($urandom));
                if ($urandom_range(0, 3) == 0 && (!slot0_only || i == 0 || i == 3))
                    set_cfg(i, $urandom_range(0, 7), 1'($urandom), W'($urandom));
            end
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_we = 1'b0; mode_in = 1'b0; upset_mode = '0;
        cfg_we = '0; cfg_in = '0; opa = '0; opb = '0; upset_cfg = '0; upset_acc = '0;
        for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_acc[i] = '0; m_res[i] = '0; end
        for (int k = 0; k < 3; k++) m_mode[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state at the ports
        for (int i = 0; i < N; i++) check("R1", cell_out[i*W +: W], '0);
        check("R1", voted_out, '0);
        set_ops(0, 16'h1234, 16'h0F0F);
        tick();
        check("R1 zero-op", cell_out[15:0], '0);

        // R3 / R5 independent mode with immediate
        cur_req = "R5";
        set_cfg(0, 2, 1'b0, '0); set_cfg(1, 1, 1'b1, 16'd7);
        set_cfg(2, 5, 1'b0, '0); set_cfg(3, 7, 1'b0, '0);
        tick();
        set_ops(1, 16'd5, 16'd999); set_ops(0, 16'd20, 16'd3);
        set_ops(2, 16'h00FF, 16'h0F0F); set_ops(3, 16'd10, 16'd0);
        tick();
        check("R3", cell_out[1*W +: W], 16'd12);
        check("R5", voted_out, 16'd17);
        check("R2", cell_out[2*W +: W], 16'h0FF0);

        // R4 accumulator
        cur_req = "R4";
        set_cfg(3, 6, 1'b0, '0);
        tick();
        set_ops(3, 16'd2, 16'd3);
        tick();
        check("R4", cell_out[3*W +: W], 16'd16);
        tick();
        check("R4", cell_out[3*W +: W], 16'd22);

        cur_req = "R2";
        random_run(40, 1'b0);

        // R6 / R7 redundant mode
        cur_req = "R6";
        mode_we = 1'b1; mode_in = 1'b1;
        tick();
        set_cfg(0, 1, 1'b0, '0); set_cfg(1, 5, 1'b1, 16'hFFFF); set_cfg(2, 3, 1'b0, '0);
        tick();
        set_ops(0, 16'd100, 16'd23); set_ops(1, 16'd1, 16'd1); set_ops(2, 16'd2, 16'd2);
        set_cfg(3, 3, 1'b0, '0);
        tick();
        set_ops(3, 16'hF0F0, 16'h0FF0);
        tick();
        check("R6", cell_out[1*W +: W], 16'd123);
        check("R6", cell_out[2*W +: W], 16'd123);
        check("R7", voted_out, 16'd123);
        check("R8", cell_out[3*W +: W], 16'h00F0);

        cur_req = "R7";
        random_run(40, 1'b0);

        // R9 replica upsets
        cur_req = "R9";
        set_cfg(0, 6, 1'b0, '0);
        tick();
        upset_cfg[1*CW + W + 1] = 1'b1;
        tick();
        for (int t = 0; t < 8; t++) begin
            set_ops(0, W'($urandom), W'($urandom)); set_ops(1, W'($urandom), '0);
            tick();
            check("R9 cfg", voted_out, cell_out[15:0]);
            check("R9 cfg", voted_out, m_res[2]);
        end
        set_cfg(0, 7, 1'b0, '0);
        tick();
        set_ops(0, 16'd9, 16'd0);
        tick();
        set_cfg(0, 6, 1'b0, '0);
        tick();
        upset_acc[2*W + 3] = 1'b1;
        tick();
        for (int t = 0; t < 8; t++) begin
            set_ops(0, W'($urandom), W'($urandom));
            tick();
            check("R9 acc", voted_out, m_res[0]);
            check("R9 acc", voted_out, cell_out[1*W +: W]);
        end

        // R10 mode copy upsets
        cur_req = "R10";
        set_cfg(0, 1, 1'b0, '0);
        tick();
        upset_mode = 3'b010;
        tick();
        upset_mode = 3'b001;
        tick();
        set_ops(0, 16'd40, 16'd2); set_ops(1, 16'd7, 16'd7);
        tick();
        check("R10", cell_out[1*W +: W], 16'd42);
        check("R10", voted_out, 16'd42);
        upset_mode = 3'b100;
        set_ops(0, 16'd1, 16'd1);
        tick();
        tick();
        check("R10", cell_out[2*W +: W], 16'd2);

        // R11 upsets on top of writes, back in independent mode
        cur_req = "R11";
        mode_we = 1'b1; mode_in = 1'b0;
        tick();
        set_cfg(3, 7, 1'b0, '0); set_ops(3, 16'h0100, 16'd0);
        tick();
        tick();
        set_cfg(3, 6, 1'b0, '0);
        tick();
        upset_acc[3*W] = 1'b1;
        tick();
        check("R11 acc", cell_out[3*W +: W], 16'h0100);
        tick();
        check("R11 acc", cell_out[3*W +: W], 16'h0101);
        set_cfg(2, 1, 1'b1, 16'h0010);
        upset_cfg[2*CW] = 1'b1;
        tick();
        set_ops(2, 16'd1, 16'd0);
        tick();
        check("R11 cfg", cell_out[2*W +: W], 16'h0012);
        set_cfg(1, 4, 1'b0, '0);
        tick();
        set_ops(1, 16'h00F0, 16'h000F);
        tick();
        check("R5", cell_out[1*W +: W], 16'h00FF);

        cur_req = "R8";
        random_run(30, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule